// File: doc/BRIEF.md
# Mailbox Interrupt and Vector Controller

This block produces the one external interrupt request of a DSP-to-host mailbox interface. The request is raised when the DSP writes its outgoing command byte, which sets a busy flag. It stays raised until the host writes zero to that flag. A configuration input can hold the request off without losing the pending flag.

When the host answers with interrupt-acknowledge strobes, the block supplies a vector on the data bus. The vector is the current content of the DSP command byte. A bus-style input sets which strobe of the acknowledge sequence carries the vector. In one style it is the first strobe. In the other it is the second, and the first strobe is left free for an external interrupt controller. The data bus is given as a value plus an output enable, and the pad logic does the tri-stating.

All inputs are synchronous to `clk`. The reset is synchronous and active low.

Top module: `mbx_irq_vec_ctrl`

## Requirements
- R1: A cycle with `dsp_cmd_we` high stores `dsp_cmd_wdata` as the command byte. It also sets `busy`, which reads 1 after that clock edge.
- R2: A host write (`host_busy_we` high) with `host_busy_wdata` = 0 clears `busy` at the next clock edge. A host write of 1 leaves `busy` unchanged. No other event clears `busy`.
- R3: When the DSP write and a host write of 0 happen in the same cycle, the DSP write wins and `busy` stays 1.
- R4: `irq_n` is active low. It equals NOT(`busy` AND `mask_en`) registered for one clock, so it falls one clock after `busy` rises.
- R5: While `mask_en` = 0, `irq_n` stays high a clock later and no vector is driven. `busy` keeps its value, so the request reappears once `mask_en` returns to 1.
- R6: With `style_two_pulse` = 0, the vector is driven during the first low pulse of `iack_n` in a sequence.
- R7: With `style_two_pulse` = 1, `vec_oe` stays 0 during the first `iack_n` pulse and goes to 1 during the second.
- R8: A pulse counter saturates at two. Any further pulses of the same sequence drive no vector in either style.
- R9: `vec_oe` is 1 only while `iack_n` is low on the selected pulse with a request pending. `vec_data` is 0 whenever `vec_oe` is 0.
- R10: The pulse counter returns to zero whenever no request is pending (busy released, masked, or acknowledge without a request). Such acknowledge pulses drive no vector.
- R11: The vector is the live command byte. A DSP write in the middle of a sequence changes the value driven on the next pulse.
- R12: After reset, `busy` = 0, `irq_n` = 1 and `vec_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_cmd_we | input | 1 | DSP writes the outgoing command byte |
| dsp_cmd_wdata | input | 8 | Command byte written by the DSP |
| host_busy_we | input | 1 | Host writes the busy flag |
| host_busy_wdata | input | 1 | Value the host writes (0 clears busy) |
| mask_en | input | 1 | 1 lets the request reach `irq_n` |
| style_two_pulse | input | 1 | 0: vector on first strobe, 1: vector on second strobe |
| iack_n | input | 1 | Interrupt-acknowledge strobe, active low |
| busy | output | 1 | Busy flag as seen by the host |
| irq_n | output | 1 | Interrupt request, active low |
| vec_data | output | 8 | Vector value for the data bus |
| vec_oe | output | 1 | Data-bus output enable for the vector |

## Verification
The bench targets the simultaneous DSP write and host clear. A design that gave the host priority would drop an interrupt the DSP had just posted. It checks pulse selection in both bus styles and the third pulse of a sequence. A wrong pulse count would drive the bus on the first strobe and collide with the external controller, or drive on a stray strobe. It also checks a sequence begun after a release, and an acknowledge with nothing pending. A counter that is not cleared would put the vector on the wrong pulse of the next sequence. A DSP rewrite between pulses exposes a vector captured too early. A masked request exposes a mask that wrongly clears `busy`.

// File: rtl/mbx_irq_pkg.sv
// Package: shared types for the mailbox interrupt and vector controller.
// Assumes: nothing beyond the standard.
package mbx_irq_pkg;
    // Which acknowledge strobe carries the vector.
    typedef enum logic {
        STYLE_ONE_PULSE = 1'b0,
        STYLE_TWO_PULSE = 1'b1
    } bus_style_e;

    // Number of strobes the pulse counter tracks before saturating.
    localparam int unsigned PULSES_TRACKED = 2;
endpackage

// File: rtl/mbx_cmd_busy.sv
// Module: holds the DSP command byte and the busy flag.
// A DSP write stores the byte and sets busy. A host write of 0 clears busy.
// The DSP write wins on a collision.
// Assumes: all inputs synchronous to clk.
module mbx_cmd_busy #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dsp_cmd_we,
    input  logic [VEC_W-1:0] dsp_cmd_wdata,
    input  logic             host_busy_we,
    input  logic             host_busy_wdata,
    output logic             busy_q,
    output logic [VEC_W-1:0] cmd_q
);
    logic host_clear;
    assign host_clear = host_busy_we && !host_busy_wdata;

    // Purpose: capture the command byte on each DSP write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (dsp_cmd_we)
            cmd_q <= dsp_cmd_wdata;
    end

    // Purpose: set on a DSP write, clear on a host write of 0, DSP first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (dsp_cmd_we)
            busy_q <= 1'b1;
        else if (host_clear)
            busy_q <= 1'b0;
    end

    // R1: a DSP write leaves busy set
    a_r1_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_cmd_we |=> busy_q);
    // R2: busy only falls after a host write of 0
    a_r2_clear_only_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(host_busy_we && !host_busy_wdata));
    // R3: a collision never clears busy
    a_r3_dsp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_cmd_we && host_busy_we && !host_busy_wdata) |=> busy_q);
endmodule

// File: rtl/mbx_iack_seq.sv
// Module: counts acknowledge strobes and picks the one that carries the vector.
// A strobe is counted when iack_n returns high. The count saturates and
// returns to zero whenever no request is pending.
// Assumes: iack_n is synchronous to clk and lasts at least one clock.
module mbx_iack_seq #(
    parameter int unsigned PULSE_MAX = mbx_irq_pkg::PULSES_TRACKED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iack_n,
    input  logic pending,
    input  logic two_pulse,
    output logic vec_sel
);
    import mbx_irq_pkg::*;

    localparam int unsigned CNT_W = $clog2(PULSE_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PULSE_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic             iack_prev_q;
    logic             pulse_end;
    logic [CNT_W-1:0] target;
    bus_style_e       style;

    assign style     = bus_style_e'(two_pulse);
    assign pulse_end = !iack_prev_q && iack_n;

    // Purpose: map the bus style to the index of the vector-bearing strobe.
    always_comb begin
        case (style)
            STYLE_TWO_PULSE: target = CNT_W'(1);
            default:         target = '0;
        endcase
    end

    // Purpose: remember last strobe level to find the end of each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            iack_prev_q <= 1'b1;
        else
            iack_prev_q <= iack_n;
    end

    // Purpose: count finished strobes, saturating, zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!pending)
            cnt_q <= '0;
        else if (pulse_end && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Purpose: enable the vector only while the selected strobe is low.
    always_comb begin
        vec_sel = !iack_n && pending && (cnt_q == target);
    end

    // R8: the counter never passes its saturation value
    a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    // R9: the enable is never raised outside a low strobe
    a_r9_sel_only_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_sel |-> !iack_n);
    // R10: an idle cycle leaves the counter at zero
    a_r10_idle_resets_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> (cnt_q == '0));
endmodule

// File: rtl/mbx_irq_drv.sv
// Module: registers the active-low interrupt request from busy and mask.
// Assumes: busy and mask_en are synchronous to clk.
module mbx_irq_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic mask_en,
    output logic irq_n
);
    // Purpose: one-clock registered, active-low request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= !(busy && mask_en);
    end

    // R4: a falling request follows a masked-in busy flag
    a_r4_irq_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(busy));
    // R5: two masked cycles in a row keep the request high
    a_r5_mask_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_en && $past(!mask_en)) |-> irq_n);
endmodule

// File: rtl/mbx_irq_vec_ctrl.sv
// Module: top of the mailbox interrupt and vector controller.
// Raises irq_n on a DSP command write and releases it on a host clear.
// Drives the command byte as the vector on the strobe the bus style selects.
// Assumes: synchronous inputs, and the pads tri-state from vec_oe.
module mbx_irq_vec_ctrl #(
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned PULSE_MAX = mbx_irq_pkg::PULSES_TRACKED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dsp_cmd_we,
    input  logic [VEC_W-1:0] dsp_cmd_wdata,
    input  logic             host_busy_we,
    input  logic             host_busy_wdata,
    input  logic             mask_en,
    input  logic             style_two_pulse,
    input  logic             iack_n,
    output logic             busy,
    output logic             irq_n,
    output logic [VEC_W-1:0] vec_data,
    output logic             vec_oe
);
    logic [VEC_W-1:0] cmd_q;
    logic             pending;

    mbx_cmd_busy #(.VEC_W(VEC_W)) u_cmd_busy (
        .clk             (clk),
        .rst_n           (rst_n),
        .dsp_cmd_we      (dsp_cmd_we),
        .dsp_cmd_wdata   (dsp_cmd_wdata),
        .host_busy_we    (host_busy_we),
        .host_busy_wdata (host_busy_wdata),
        .busy_q          (busy),
        .cmd_q           (cmd_q)
    );

    // Purpose: a request is pending when busy is set and not masked.
    always_comb begin
        pending = busy && mask_en;
    end

    mbx_iack_seq #(.PULSE_MAX(PULSE_MAX)) u_iack_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack_n    (iack_n),
        .pending   (pending),
        .two_pulse (style_two_pulse),
        .vec_sel   (vec_oe)
    );

    mbx_irq_drv u_irq_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .mask_en (mask_en),
        .irq_n   (irq_n)
    );

    // Purpose: present the live command byte only while enabled.
    always_comb begin
        vec_data = vec_oe ? cmd_q : '0;
    end

    // R6 R7: a vector only goes out for an unmasked busy request
    a_r6_oe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (busy && mask_en));
    // R9: the bus value is zero whenever the enable is low
    a_r9_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_data == '0));
endmodule

// File: tb/mbx_irq_vec_ctrl_tb.sv
module mbx_irq_vec_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dsp_cmd_we = 1'b0;
    logic [7:0] dsp_cmd_wdata = 8'h00;
    logic       host_busy_we = 1'b0;
    logic       host_busy_wdata = 1'b1;
    logic       mask_en = 1'b1;
    logic       style_two_pulse = 1'b0;
    logic       iack_n = 1'b1;
    logic       busy, irq_n, vec_oe;
    logic [7:0] vec_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mbx_irq_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dsp_cmd_we(dsp_cmd_we), .dsp_cmd_wdata(dsp_cmd_wdata),
        .host_busy_we(host_busy_we), .host_busy_wdata(host_busy_wdata), .mask_en(mask_en),
        .style_two_pulse(style_two_pulse), .iack_n(iack_n), .busy(busy), .irq_n(irq_n),
        .vec_data(vec_data), .vec_oe(vec_oe)
    );

    // Behavioural reference state
    bit       m_busy = 0;
    bit       m_irq_n = 1;
    bit [7:0] m_cmd = 0;
    int       m_strobes = 0;
    bit       m_prev = 1;

    function automatic bit m_oe();
        int want;
        want = style_two_pulse ? 1 : 0;
        return !iack_n && m_busy && mask_en && (m_strobes == want);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_irq_n <= 1; m_cmd <= 0; m_strobes <= 0; m_prev <= 1;
        end else begin
            m_irq_n <= !(m_busy && mask_en);
            if (dsp_cmd_we) m_cmd <= dsp_cmd_wdata;
            if (dsp_cmd_we) m_busy <= 1;
            else if (host_busy_we && !host_busy_wdata) m_busy <= 0;
            if (!(m_busy && mask_en)) m_strobes <= 0;
            else if (!m_prev && iack_n && m_strobes < 2) m_strobes <= m_strobes + 1;
            m_prev <= iack_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            check(irq_n == m_irq_n, "R4 irq_n", irq_n, m_irq_n);
            check(busy == m_busy, "R2 busy", busy, m_busy);
            check(vec_oe == m_oe(), "R9 vec_oe", vec_oe, m_oe());
            check(vec_data == (m_oe() ? m_cmd : 8'h00), "R11 vec_data", vec_data,
                  m_oe() ? m_cmd : 8'h00);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic dsp_write(input logic [7:0] v);
        dsp_cmd_we = 1; dsp_cmd_wdata = v; tick(); dsp_cmd_we = 0;
    endtask

    task automatic host_write(input logic v);
        host_busy_we = 1; host_busy_wdata = v; tick(); host_busy_we = 0; host_busy_wdata = 1;
    endtask

    // One strobe: low one clock, then high one clock; reports enable and data seen while low
    task automatic strobe(output logic oe, output logic [7:0] d);
        iack_n = 0;
        @(negedge clk); oe = vec_oe; d = vec_data;
        tick(); iack_n = 1; tick();
    endtask

    initial begin
        logic       oe;
        logic [7:0] d;
        repeat (3) tick();
        @(negedge clk);
        check(irq_n == 1 && vec_oe == 0 && busy == 0, "R12 reset state",
              {busy, irq_n, vec_oe}, 3'b010);
        tick(); rst_n = 1; tick();

        // R1, R4
        dsp_write(8'hA5);
        @(negedge clk);
        check(busy == 1, "R1 busy set", busy, 1);
        check(irq_n == 1, "R4 latency", irq_n, 1);
        tick(); @(negedge clk);
        check(irq_n == 0, "R4 irq asserted", irq_n, 0);
        tick();

        // R6 single style, R8 second strobe quiet
        strobe(oe, d);
        check(oe == 1 && d == 8'hA5, "R6 first strobe vector", {oe, d}, {1'b1, 8'hA5});
        strobe(oe, d);
        check(oe == 0, "R8 later strobe quiet", oe, 0);

        // R2 write of 1 no effect, then clear
        host_write(1'b1);
        @(negedge clk); check(busy == 1, "R2 write one ignored", busy, 1);
        tick();
        host_write(1'b0);
        @(negedge clk); check(busy == 0, "R2 clear", busy, 0);
        tick(); @(negedge clk); check(irq_n == 1, "R4 released", irq_n, 1);
        tick();

        // R10 strobe with nothing pending
        strobe(oe, d);
        check(oe == 0 && d == 0, "R10 no request no vector", {oe, d}, 0);

        // R7 two-pulse style, R8 third strobe
        style_two_pulse = 1;
        dsp_write(8'h3C); tick();
        strobe(oe, d); check(oe == 0, "R7 first strobe free", oe, 0);
        strobe(oe, d); check(oe == 1 && d == 8'h3C, "R7 second strobe vector", {oe, d}, {1'b1, 8'h3C});
        strobe(oe, d); check(oe == 0, "R8 third strobe quiet", oe, 0);

        // R10 new sequence after release starts fresh; R11 live byte
        host_write(1'b0); tick();
        dsp_write(8'h77); tick();
        strobe(oe, d); check(oe == 0, "R10 fresh sequence first strobe", oe, 0);
        dsp_write(8'h99);
        strobe(oe, d); check(oe == 1 && d == 8'h99, "R11 live vector", {oe, d}, {1'b1, 8'h99});

        // R3 collision
        host_busy_we = 1; host_busy_wdata = 0; dsp_cmd_we = 1; dsp_cmd_wdata = 8'h12;
        tick(); host_busy_we = 0; host_busy_wdata = 1; dsp_cmd_we = 0;
        @(negedge clk); check(busy == 1, "R3 dsp wins", busy, 1);
        tick();

        // R5 masking
        mask_en = 0; tick(); tick();
        @(negedge clk);
        check(irq_n == 1, "R5 masked irq high", irq_n, 1);
        check(busy == 1, "R5 busy kept", busy, 1);
        style_two_pulse = 0;
        strobe(oe, d); check(oe == 0, "R5 masked no vector", oe, 0);
        mask_en = 1; tick(); @(negedge clk);
        check(irq_n == 0, "R5 unmasked irq back", irq_n, 0);
        tick();
        strobe(oe, d); check(oe == 1 && d == 8'h12, "R6 vector after unmask", {oe, d}, {1'b1, 8'h12});

        repeat (2) tick();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule